// File: doc/BRIEF.md
# Frame Slip Elastic Buffer

This block is an elastic store for framed serial traffic carried as fixed-length frames of data words. The write side is timed by the clock recovered from the incoming line and marks the first word of a frame. The read side is timed by the local equipment clock. Because the two rates are independent, the amount of stored data wanders. Both sides are modelled here in one clock domain, with a strobe for each side.

The store holds two frames. Whenever the reader is about to start a new frame, the block looks at the fill level. If the writer is close to catching up with the reader, the next whole frame is skipped. If the reader is close to running dry, the frame just read is played again. Either action moves the fill level by exactly one frame back towards the middle of the store. The block reports each slip and its direction with a one-cycle pulse and counts slips in a saturating counter. A persistent frequency offset between the two sides therefore produces a steady, orderly series of frame slips rather than corrupted frames.

Top module: `frame_slip_buffer`

## Requirements
- R1: While reset is high, and in the first cycle after it, fill is 0 and rd_valid, rd_sof, slip_rep, slip_del and slip_cnt are all 0.
- R2: After reset, written words are discarded until a word arrives with wr_sof high. That word is stored as word 0 of a frame. Later wr_sof values have no effect on where words are stored.
- R3: Read strobes have no effect until the fill level has reached FRAME_LEN words for the first time after reset. From then on, reading stays enabled.
- R4: A read that is accepted returns its word on rd_data with rd_valid high one cycle after rd_en. Words come back in write order, except where a slip intervenes. rd_sof is high with the word at offset 0 of a frame.
- R5: When a read is about to take the word at offset 0 of a frame and fill exceeds 2*FRAME_LEN - FRAME_LEN/2, the next frame is deleted. The returned word is the one written FRAME_LEN words later, fill drops by FRAME_LEN, and slip_del is high together with that word.
- R6: When a read is about to take the word at offset 0 of a frame and fill is below FRAME_LEN/2, the previous frame is repeated. The returned word is the one written FRAME_LEN words earlier, fill rises by FRAME_LEN, and slip_rep is high together with that word.
- R7: A slip happens only at a frame boundary, with at most one slip per boundary. A slip pulse is always accompanied by rd_valid and rd_sof.
- R8: A write is dropped when the store already holds 2*FRAME_LEN words, after any slip in that cycle. A read strobe when the store is empty returns nothing.
- R9: fill equals the number of words accepted minus the read position, counted in words and including slip adjustments. It never exceeds 2*FRAME_LEN.
- R10: slip_cnt increments once per slip of either direction and holds at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe (recovered-clock side) |
| wr_sof | input | 1 | First word of a frame on the write side |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read strobe (local-clock side) |
| rd_data | output | DATA_W | Read word, registered |
| rd_valid | output | 1 | rd_data holds a word read in the previous cycle |
| rd_sof | output | 1 | Read word is at offset 0 of a frame |
| fill | output | $clog2(2*FRAME_LEN)+1 | Words currently held |
| slip_rep | output | 1 | One-cycle pulse: a frame was repeated |
| slip_del | output | 1 | One-cycle pulse: a frame was deleted |
| slip_cnt | output | SLIP_CNT_W | Saturating slip count |

## Verification
The bench drives the write side faster than the read side, and then the reverse, long enough to force many slips in each direction. A design that slipped in the middle of a frame, or moved the read position by anything other than one frame, would return out-of-sequence words or drop rd_sof. The bench fills the store to capacity and drains it to empty, which catches a design that wraps over unread data or emits stale words. It also writes before the first frame marker, which catches one that starts storing too early. A reduced counter width lets the run reach saturation, so a counter that wraps around back to zero is detected.

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
  parameter int DATA_W     = 8,
  parameter int FRAME_LEN  = 32,
  parameter int SLIP_CNT_W = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic                                wr_sof,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                rd_en,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                rd_valid,
  output logic                                rd_sof,
  output logic [$clog2(2*FRAME_LEN):0]        fill,
  output logic                                slip_rep,
  output logic                                slip_del,
  output logic [SLIP_CNT_W-1:0]               slip_cnt
);
  localparam int DEPTH = 2 * FRAME_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(FRAME_LEN);
  localparam int LO    = FRAME_LEN / 2;
  localparam int HI    = DEPTH - FRAME_LEN / 2;
  localparam logic [AW:0]   FL_C  = (AW+1)'(FRAME_LEN);
  localparam logic [AW:0]   DEP_C = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] FL_P  = AW'(FRAME_LEN);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          aligned, run_q;

  wire run    = run_q | (cnt >= FL_C);
  wire at_bnd = rd_en & run & (rp[FW-1:0] == '0);
  wire do_del = at_bnd & (cnt > (AW+1)'(HI));
  wire do_rep = at_bnd & (cnt < (AW+1)'(LO));

  wire [AW:0]   fe   = do_del ? cnt - FL_C : (do_rep ? cnt + FL_C : cnt);
  wire [AW-1:0] rp_e = (do_del | do_rep) ? rp + FL_P : rp;
  wire          wr_ok = wr_en & (aligned | wr_sof) & (fe != DEP_C);
  wire          rd_ok = rd_en & run & (fe != '0);

  assign fill = cnt;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      aligned  <= 1'b0;
      run_q    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_sof   <= 1'b0;
      slip_rep <= 1'b0;
      slip_del <= 1'b0;
      slip_cnt <= '0;
    end else begin
      if (wr_ok) begin
        wp      <= wp + 1'b1;
        aligned <= 1'b1;
      end
      run_q    <= run;
      cnt      <= fe + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
      rd_valid <= rd_ok;
      rd_sof   <= rd_ok & (rp_e[FW-1:0] == '0);
      if (rd_ok) begin
        rd_data <= mem[rp_e];
        rp      <= rp_e + 1'b1;
      end
      slip_rep <= do_rep;
      slip_del <= do_del;
      if ((do_rep | do_del) && slip_cnt != '1)
        slip_cnt <= slip_cnt + 1'b1;
    end
  end

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fill <= DEP_C);
  assert_slip_on_sof_R7: assert property (@(posedge clk) disable iff (rst)
    (slip_rep | slip_del) |-> (rd_valid & rd_sof));
  assert_slip_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(slip_rep && slip_del));
  assert_valid_needs_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (slip_cnt == '1) |=> (slip_cnt == '1));
  assert_del_drops_R5: assert property (@(posedge clk) disable iff (rst)
    slip_del |-> (fill <= DEP_C - FL_C));
endmodule

// File: tb/frame_slip_buffer_tb.sv
`timescale 1ns/1ps
module frame_slip_buffer_tb_top;
  localparam int FL = 32;
  localparam int DEPTH = 2 * FL;
  localparam int LO = FL / 2;
  localparam int HI = DEPTH - FL / 2;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sof = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_valid, rd_sof, slip_rep, slip_del;
  logic [6:0] fill;
  logic [CW-1:0] slip_cnt;

  always #2.5 clk = ~clk;

  frame_slip_buffer #(.DATA_W(8), .FRAME_LEN(FL), .SLIP_CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_sof(rd_sof),
    .fill(fill), .slip_rep(slip_rep), .slip_del(slip_del), .slip_cnt(slip_cnt));

  int nchk = 0, nerr = 0;
  int ws = 0, rs = 0, m_fill = 0, m_sc = 0;
  bit m_al = 0, m_run = 0, done = 0;
  int n_del = 0, n_rep = 0;

  // phase table: {write skip period, read skip period, cycles}
  // period 0: idle, 1: every cycle, k: active except every k-th cycle
  localparam logic [19:0] PH [7] = '{
    {4'd1, 4'd0, 12'd22},
    {4'd1, 4'd1, 12'd200},
    {4'd1, 4'd4, 12'd2000},
    {4'd4, 4'd1, 12'd2000},
    {4'd1, 4'd0, 12'd70},
    {4'd0, 4'd1, 12'd200},
    {4'd1, 4'd1, 12'd150}
  };

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit act_on(logic [3:0] per, int k);
    if (per == 0) return 1'b0;
    if (per == 1) return 1'b1;
    return (k % per) != (per - 1);
  endfunction

  task automatic cyc(bit we, bit sof, bit re);
    int fe, rse;
    bit del, rep, wok, rok, run;
    wr_en = we; wr_sof = sof; wr_data = 8'(ws); rd_en = re;
    run = m_run || (m_fill >= FL);
    del = 0; rep = 0; fe = m_fill; rse = rs;
    if (re && run && (rs % FL) == 0) begin
      if (fe > HI) begin del = 1; fe -= FL; rse = rs + FL; end
      else if (fe < LO) begin rep = 1; fe += FL; rse = rs - FL; end
    end
    wok = we && (m_al || sof) && (fe < DEPTH);
    rok = re && run && (fe != 0);
    @(negedge clk);
    if (rok) chk("R4 valid", int'(rd_valid), 1);
    else if (!run) chk("R3 read ignored", int'(rd_valid), 0);
    else chk("R8 empty read", int'(rd_valid), 0);
    if (rok) begin
      chk("R4 data", int'(rd_data), rse & 8'hFF);
      chk("R4 sof", int'(rd_sof), int'((rse % FL) == 0));
    end
    chk("R5 slip_del", int'(slip_del), int'(del));
    chk("R6 slip_rep", int'(slip_rep), int'(rep));
    if (del || rep) chk("R7 slip at boundary", int'(rd_sof), 1);
    if (wok) begin ws++; m_al = 1; end
    if (rok) rs = rse + 1;
    m_fill = fe + int'(wok) - int'(rok);
    m_run = run;
    if (del) n_del++;
    if (rep) n_rep++;
    if ((del || rep) && m_sc < CMAX) m_sc++;
    chk("R9 fill", int'(fill), m_fill);
    chk("R10 slip_cnt", int'(slip_cnt), m_sc);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fill", int'(fill), 0);
    chk("R1 valid", int'(rd_valid), 0);
    chk("R1 slips", int'(slip_rep | slip_del), 0);
    chk("R1 slip_cnt", int'(slip_cnt), 0);
    rst = 1'b0;
    // R2: words before the first marker are dropped
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0);
    chk("R2 pre-marker fill", int'(fill), 0);
    cyc(1'b1, 1'b1, 1'b0);
    chk("R2 marker stored", int'(fill), 1);
    // R3: reads before one frame is held are ignored
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 1'b1);
    chk("R3 no read yet", int'(fill), 10);
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < int'(PH[p][11:0]); k++)
        cyc(act_on(PH[p][19:16], k), 1'b0, act_on(PH[p][15:12], k));
      if (p == 0) chk("R3 one frame held", int'(fill), FL);
      if (p == 1) begin
        // R2: a later marker does not realign the store
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1);
      end
      if (p == 4) chk("R8 full store", int'(fill), DEPTH);
    end
    chk("R5 deletes seen", int'(n_del > 0), 1);
    chk("R6 repeats seen", int'(n_rep > 0), 1);
    chk("R10 saturated", int'(slip_cnt), CMAX);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule